// File: doc/BRIEF.md
# Serial Record and Playback Sequencer

This block sits between a byte-wide serial receive/transmit pair and a byte-access memory master. A host sends single-letter commands. One letter starts a recording session. In that session every following character is written to successive memory locations and echoed back, until a carriage return ends the session. A second letter replays the recorded characters in address order. The block keeps a running record length, and that length is visible on an output port.

Commands are not case-sensitive. Each accepted command is acknowledged with its upper-case letter. A zero byte read back during playback is skipped and not sent. When playback finishes, the record length returns to zero. Every memory access is a request that is held until the master answers with a done strobe. A done strobe that carries an error abandons the current session.

Top module: `rec_play_seq`

## Requirements
- R1: In idle, 0x77 ('w') or 0x57 ('W') on the receive port clears `rec_len` to 0, transmits 0x57 and starts a recording session.
- R2: In idle, 0x72 ('r') or 0x52 ('R') transmits 0x52 and starts playback. Any other byte received in idle is dropped: nothing is transmitted and no memory request is made.
- R3: In a recording session, a received byte other than 0x0D is written (`mem_we`=1) to address `rec_len` with the byte as data. After the done strobe, `rec_len` increments by one and the byte is echoed on the transmit port.
- R4: 0x0D received in a recording session ends it and returns to idle, with no memory write, no transmit and no change to `rec_len`.
- R5: Playback reads addresses 0 to `rec_len`-1 in increasing order and transmits each byte read, except that a byte equal to 0x00 is not transmitted.
- R6: When playback has handled the last address, `rec_len` becomes 0. A playback with `rec_len`=0 sends only the acknowledgement.
- R7: Received bytes are ignored while an acknowledgement is pending and throughout playback. Inside a recording session, the command letters are stored as ordinary data.
- R8: `mem_req` stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until the cycle in which `mem_done` is high. Only one request is outstanding at a time.
- R9: `mem_err` high together with `mem_done` abandons the session and returns to idle. No echo or playback byte is sent for that access, and `rec_len` does not advance.
- R10: `tx_valid` stays high with stable `tx_data` until `tx_ready`. The block never has a transmit byte and a memory request pending in the same cycle.
- R11: `rec_len` saturates at 2^CNT_W-1. A byte received at that count is echoed but not written, so earlier bytes are not overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe marking `rx_data` valid |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | Transmit byte pending |
| tx_ready | input | 1 | Transmitter accepts the pending byte this cycle |
| mem_req | output | 1 | Memory access request, held until done |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | CNT_W | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with `mem_done` |
| mem_done | input | 1 | One-cycle completion strobe |
| mem_err | input | 1 | Access failed, valid with `mem_done` |
| rec_len | output | CNT_W | Current record length |

## Verification
A wrong state shows up at the ports within a single memory or transmit handshake. If the mode is wrong, a received letter is echoed or written when it should be dropped, or the acknowledgement is missing. If the counter is off, the write address of the next recorded byte is wrong, and so are the number and order of addresses read during playback. A missing clear shows up on `rec_len` as soon as playback ends. An error that is not handled produces an echo the bench does not expect. A saturation fault shows up as an extra write at the last address.

// File: rtl/rec_play_seq.sv
module rec_play_seq #(
  parameter int CNT_W = 16,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    rx_data,
  input  logic             rx_valid,
  output logic [DW-1:0]    tx_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic [CNT_W-1:0] mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_done,
  input  logic             mem_err,
  output logic [CNT_W-1:0] rec_len
);

  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};
  localparam logic [DW-1:0] CH_W_UP = DW'(8'h57);
  localparam logic [DW-1:0] CH_W_LO = DW'(8'h77);
  localparam logic [DW-1:0] CH_R_UP = DW'(8'h52);
  localparam logic [DW-1:0] CH_R_LO = DW'(8'h72);
  localparam logic [DW-1:0] CH_CR   = DW'(8'h0D);

  typedef enum logic [2:0] {
    S_IDLE, S_ACK, S_RWAIT, S_RWR, S_ECHO, S_PRD, S_PTX
  } st_t;

  st_t               st;
  logic              to_rec;
  logic [CNT_W-1:0]  cnt, idx;
  logic [DW-1:0]     byte_q;
  logic              last;

  assign tx_valid  = (st == S_ACK) || (st == S_ECHO) || (st == S_PTX);
  assign tx_data   = byte_q;
  assign mem_req   = (st == S_RWR) || (st == S_PRD);
  assign mem_we    = (st == S_RWR);
  assign mem_addr  = (st == S_RWR) ? cnt : idx;
  assign mem_wdata = byte_q;
  assign rec_len   = cnt;
  assign last      = (idx == cnt - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      to_rec <= 1'b0;
      cnt    <= '0;
      idx    <= '0;
      byte_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (rx_valid) begin
          if (rx_data == CH_W_LO || rx_data == CH_W_UP) begin
            cnt    <= '0;
            byte_q <= CH_W_UP;
            to_rec <= 1'b1;
            st     <= S_ACK;
          end else if (rx_data == CH_R_LO || rx_data == CH_R_UP) begin
            idx    <= '0;
            byte_q <= CH_R_UP;
            to_rec <= 1'b0;
            st     <= S_ACK;
          end
        end
        S_ACK: if (tx_ready) begin
          if (to_rec)         st <= S_RWAIT;
          else if (cnt == '0) st <= S_IDLE;
          else                st <= S_PRD;
        end
        S_RWAIT: if (rx_valid) begin
          if (rx_data == CH_CR) st <= S_IDLE;
          else begin
            byte_q <= rx_data;
            st     <= (cnt == FULL) ? S_ECHO : S_RWR;
          end
        end
        S_RWR: if (mem_done) begin
          if (mem_err) st <= S_IDLE;
          else begin
            cnt <= cnt + 1'b1;
            st  <= S_ECHO;
          end
        end
        S_ECHO: if (tx_ready) st <= S_RWAIT;
        S_PRD: if (mem_done) begin
          if (mem_err) st <= S_IDLE;
          else if (mem_rdata != '0) begin
            byte_q <= mem_rdata;
            st     <= S_PTX;
          end else if (last) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_PTX: if (tx_ready) begin
          if (last) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else begin
            idx <= idx + 1'b1;
            st  <= S_PRD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R8
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R10
  AST_ONE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && mem_req)); // R10
  AST_NO_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr != FULL)); // R11
  AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rec_len == $past(rec_len) || rec_len == $past(rec_len) + 1'b1 || rec_len == '0)); // R3
  AST_ERR_NO_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_done && mem_err) |=> !tx_valid && !mem_req); // R9

endmodule

// File: tb/test_rec_play_seq.sv
module test_rec_play_seq;
  localparam int CW = 4;
  localparam int LAT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0;
  logic [7:0] tx_data;
  logic tx_valid;
  logic tx_ready;
  logic mem_req, mem_we;
  logic [CW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = '0;
  logic mem_done = 1'b0, mem_err = 1'b0;
  logic [CW-1:0] rec_len;

  always #5 clk = ~clk;

  rec_play_seq #(.CNT_W(CW), .DW(8)) i_rec_play_seq (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_done(mem_done), .mem_err(mem_err), .rec_len(rec_len));

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] mem [0:15];
  logic [7:0] txq [0:255];
  int txn = 0;
  int rd_log [0:255];
  int rdn = 0;
  int wr_log [0:255];
  int wrn = 0;
  int lat = 0;
  logic inj_err = 1'b0;
  logic slow = 1'b0;
  logic tog = 1'b0;

  assign tx_ready = slow ? tog : 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    tog <= ~tog;
    if (tx_valid && tx_ready) begin
      txq[txn] = tx_data;
      txn = txn + 1;
    end
    if (mem_req && !mem_done) begin
      if (lat == LAT) begin
        lat = 0;
        mem_done <= 1'b1;
        mem_err  <= inj_err;
        if (mem_we) begin
          if (!inj_err) mem[mem_addr] = mem_wdata;
          wr_log[wrn] = int'(mem_addr);
          wrn = wrn + 1;
        end else begin
          mem_rdata <= mem[mem_addr];
          rd_log[rdn] = int'(mem_addr);
          rdn = rdn + 1;
        end
      end else lat = lat + 1;
    end else begin
      mem_done <= 1'b0;
      mem_err  <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
    repeat (14) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!tx_valid, "R10", int'(tx_valid), 0);
    chk(!mem_req, "R8", int'(mem_req), 0);
    chk(rec_len == 0, "R1", int'(rec_len), 0);
  endtask

  task automatic t_idle_ignore;
    int t0 = txn, w0 = wrn, r0 = rdn;
    put(8'h78); put(8'h0D);
    chk(txn == t0, "R2 idle tx", txn - t0, 0);
    chk(wrn == w0 && rdn == r0, "R2 idle mem", wrn + rdn - w0 - r0, 0);
  endtask

  task automatic t_record;
    int t0 = txn, w0 = wrn;
    put(8'h77);
    chk(txn == t0 + 1 && txq[t0] == 8'h57, "R1 ack", int'(txq[t0]), 8'h57);
    chk(rec_len == 0, "R1 len", int'(rec_len), 0);
    put(8'h61); put(8'h00); put(8'h72);
    chk(wr_log[w0] == 0 && wr_log[w0+1] == 1 && wr_log[w0+2] == 2, "R3 addr", wr_log[w0+2], 2);
    chk(mem[0] == 8'h61 && mem[1] == 8'h00, "R3 data", int'(mem[0]), 8'h61);
    chk(mem[2] == 8'h72, "R7 letter stored", int'(mem[2]), 8'h72);
    chk(txq[t0+1] == 8'h61 && txq[t0+3] == 8'h72, "R3 echo", int'(txq[t0+3]), 8'h72);
    chk(rec_len == 3, "R3 len", int'(rec_len), 3);
    put(8'h0D);
    chk(txn == t0 + 4 && wrn == w0 + 3, "R4 cr", txn - t0, 4);
    chk(rec_len == 3, "R4 len", int'(rec_len), 3);
  endtask

  task automatic t_play;
    int t0 = txn, r0 = rdn;
    slow = 1'b1;
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h72;
    @(negedge clk); rx_valid = 1'b0;
    repeat (3) @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h57;
    @(negedge clk); rx_valid = 1'b0;
    repeat (40) @(negedge clk);
    slow = 1'b0;
    chk(txq[t0] == 8'h52, "R2 ack", int'(txq[t0]), 8'h52);
    chk(txn == t0 + 3, "R5 count", txn - t0, 3);
    chk(txq[t0+1] == 8'h61 && txq[t0+2] == 8'h72, "R5 bytes", int'(txq[t0+2]), 8'h72);
    chk(rdn == r0 + 3 && rd_log[r0] == 0 && rd_log[r0+1] == 1 && rd_log[r0+2] == 2, "R5 order", rdn - r0, 3);
    chk(rec_len == 0, "R6 clear", int'(rec_len), 0);
    chk(txq[t0+1] != 8'h57, "R7 ignored", int'(txq[t0+1]), 8'h61);
    t0 = txn; r0 = rdn;
    put(8'h52);
    chk(txn == t0 + 1 && rdn == r0, "R6 empty play", txn - t0, 1);
  endtask

  task automatic t_reclear;
    put(8'h57); put(8'h41); put(8'h42); put(8'h0D);
    chk(rec_len == 2, "R3 len2", int'(rec_len), 2);
    put(8'h77);
    chk(rec_len == 0, "R1 reclear", int'(rec_len), 0);
    put(8'h0D);
  endtask

  task automatic t_error;
    int t0;
    put(8'h57);
    t0 = txn;
    inj_err = 1'b1;
    put(8'h71);
    inj_err = 1'b0;
    chk(txn == t0, "R9 no echo", txn - t0, 0);
    chk(rec_len == 0, "R9 len", int'(rec_len), 0);
    put(8'h7A);
    chk(txn == t0, "R9 idle", txn - t0, 0);
  endtask

  task automatic t_sat;
    int t0, w0;
    put(8'h77);
    t0 = txn; w0 = wrn;
    for (int i = 0; i < 17; i++) put(8'h41 + 8'(i));
    chk(rec_len == 15, "R11 sat", int'(rec_len), 15);
    chk(wrn == w0 + 15, "R11 writes", wrn - w0, 15);
    chk(txn == t0 + 17, "R11 echo", txn - t0, 17);
    chk(mem[14] == 8'h4F, "R11 kept", int'(mem[14]), 8'h4F);
    put(8'h0D);
    t0 = txn;
    put(8'h72);
    repeat (80) @(negedge clk);
    chk(txn == t0 + 16 && txq[t0+15] == 8'h4F, "R5 full play", txn - t0, 16);
    chk(rec_len == 0, "R6 clear full", int'(rec_len), 0);
  endtask

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(negedge clk) if (cyc > 150000) begin
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    finish_up();
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'hEE;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_idle_ignore();
    t_record();
    t_play();
    t_reclear();
    t_error();
    t_sat();
    finish_up();
  end
endmodule